// File: doc/BRIEF.md
# ECC Error Capture and Interrupt Unit

This unit sits beside a memory ECC checker. Each cycle the checker may present an error event, marked as single-bit (correctable) or multi-bit (uncorrectable). The event carries the 64-bit data word as read, the check syndrome and the 64-bit memory address. The unit keeps a sticky status flag for each error kind and a snapshot of the diagnostic values. It raises an interrupt line when an enabled flag is set. Software reads and clears the flags through a small word-addressed register port.

Multi-bit errors set their flag at once. Single-bit errors pass through a counter with a programmable threshold, so software can ask to be woken only after a given number of correctable errors. A per-kind disable mask suppresses detection entirely. The capture registers freeze once any flag is set, so the diagnostic values describe the first error that raised a flag and are kept until software clears the status.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Word 0 is the status register: bit 0 is the single-bit flag and bit 1 is the multi-bit flag. Writing 1 to a bit clears that flag, writing 0 leaves it unchanged, and writing 0xFFFFFFFF clears both flags.
- R3: An accepted multi-bit event sets status bit 1, visible on the clock edge that samples the event.
- R4: Word 3 holds the single-bit event count in bits 7:0 and the threshold in bits 23:16. Each accepted single-bit event increments the count. When the incremented count equals a nonzero threshold, the event sets status bit 0 and the count returns to 0. With threshold 1 every event sets the flag. With threshold 0 the flag is never set and the count wraps.
- R5: A set flag stays set until software clears it, whatever events follow. When an event sets a flag in the same cycle that a status write clears it, the flag ends up set.
- R6: The capture words load on any accepted event while both flags are clear, and hold their values otherwise. The words are: 4 = data bits 63:32, 5 = data bits 31:0, 6 = syndrome, 7 = address bits 31:0, 8 = address bits 63:32. The gate uses the flag values from before any status write in the same cycle.
- R7: Word 1 is the detection disable mask (bit 0 single-bit, bit 1 multi-bit). A disabled event does not count, does not set a flag and does not capture.
- R8: With `cfg_narrow` low (64-bit bus) the captured syndrome keeps bits 7:0 and the rest read zero. With `cfg_narrow` high (32-bit bus) it keeps bits 15:0.
- R9: Word 2 holds the interrupt enables (bit 0 single-bit, bit 1 multi-bit). `irq` is the OR over both kinds of (flag AND enable) and follows the flags without an extra register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| err_valid | input | 1 | Error event present this cycle |
| err_sbe | input | 1 | Event is a single-bit error |
| err_mbe | input | 1 | Event is a multi-bit error |
| err_data | input | 64 | Data word read with the error |
| err_syndrome | input | 16 | Check syndrome of the event |
| err_addr | input | 64 | Memory address of the event |
| cfg_narrow | input | 1 | 1 = 32-bit bus mode for syndrome masking |
| irq | output | 1 | Interrupt request |

## Verification
A software clear of the status register and a new error from the checker can land on the same clock edge. The bench sets the multi-bit flag, then drives a status write of all ones together with a fresh multi-bit event in one cycle. It expects the flag to stay set, because the set takes priority over the clear. It also expects the capture words to still hold the earlier event, because the capture gate looks at the flags from before the write.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
   localparam int REG_DW  = 32;
   localparam int REG_AW  = 4;
   localparam int NKIND   = 2;
   localparam int K_SBE   = 0;
   localparam int K_MBE   = 1;
   localparam int THR_LSB = 16;

   typedef enum logic [REG_AW-1:0] {
      RA_STATUS  = 4'd0,
      RA_DISABLE = 4'd1,
      RA_IRQEN   = 4'd2,
      RA_SBECTL  = 4'd3,
      RA_CAP_DHI = 4'd4,
      RA_CAP_DLO = 4'd5,
      RA_CAP_SYN = 4'd6,
      RA_CAP_ALO = 4'd7,
      RA_CAP_AHI = 4'd8
   } reg_addr_e;
endpackage

// File: rtl/ecap_sbe_counter.sv
module ecap_sbe_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sbe_evt,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_cnt,
   input  logic [CNT_W-1:0] wr_thr,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] thr,
   output logic             hit
);
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("ecap_sbe_counter: CNT_W must be 1..8");
   end

   logic [CNT_W-1:0] cnt_inc;
   assign cnt_inc = cnt + CNT_W'(1);
   assign hit     = sbe_evt && (thr != '0) && (cnt_inc == thr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         thr <= '0;
      end else if (wr_en) begin
         cnt <= wr_cnt;
         thr <= wr_thr;
      end else if (hit) begin
         cnt <= '0;
      end else if (sbe_evt) begin
         cnt <= cnt_inc;
      end
   end

   AST_HIT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !wr_en) |=> (cnt == '0)); // R4
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!sbe_evt && !wr_en) |=> $stable(cnt)); // R4
endmodule

// File: rtl/ecap_status.sv
module ecap_status #(
   parameter int NK      = 2,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NK-1:0] set,
   input  logic [NK-1:0] clr,
   input  logic [NK-1:0] en,
   output logic [NK-1:0] flags,
   output logic          irq
);
   if (NK < 1) begin : g_bad_nk
      $error("ecap_status: NK must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr) | set;
   end

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(flags & en);
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = |(flags & en);
   end

   for (genvar k = 0; k < NK; k++) begin : g_chk
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[k] && !clr[k]) |=> flags[k]); // R5
      AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
         set[k] |=> flags[k]); // R3
   end
endmodule

// File: rtl/ecap_capture.sv
module ecap_capture #(
   parameter int DATA_W  = 64,
   parameter int ADDR_W  = 64,
   parameter int SYN_W   = 16,
   parameter int WIDE_SW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              pending,
   input  logic              narrow,
   input  logic [DATA_W-1:0] data,
   input  logic [SYN_W-1:0]  syn,
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] cap_data,
   output logic [SYN_W-1:0]  cap_syn,
   output logic [ADDR_W-1:0] cap_addr
);
   if (WIDE_SW > SYN_W) begin : g_bad_syn
      $error("ecap_capture: WIDE_SW must not exceed SYN_W");
   end

   localparam logic [SYN_W-1:0] WIDE_MASK = SYN_W'((1 << WIDE_SW) - 1);

   logic             load;
   logic [SYN_W-1:0] syn_m;
   assign load  = accept && !pending;
   assign syn_m = narrow ? syn : (syn & WIDE_MASK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_data <= '0;
         cap_syn  <= '0;
         cap_addr <= '0;
      end else if (load) begin
         cap_data <= data;
         cap_syn  <= syn_m;
         cap_addr <= addr;
      end
   end

   AST_CAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      pending |=> ($stable(cap_data) && $stable(cap_addr) && $stable(cap_syn))); // R6
   AST_WIDE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !narrow) |=> ((cap_syn & ~WIDE_MASK) == '0)); // R8
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
   import ecap_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int ADDR_W  = 64,
   parameter int SYN_W   = 16,
   parameter int WIDE_SW = 8,
   parameter int CNT_W   = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   input  logic              err_valid,
   input  logic              err_sbe,
   input  logic              err_mbe,
   input  logic [DATA_W-1:0] err_data,
   input  logic [SYN_W-1:0]  err_syndrome,
   input  logic [ADDR_W-1:0] err_addr,
   input  logic              cfg_narrow,
   output logic              irq
);
   if (DATA_W != 2 * REG_DW) begin : g_bad_data
      $error("ecc_err_capture: DATA_W must be two register words");
   end
   if (ADDR_W <= REG_DW || ADDR_W > 2 * REG_DW) begin : g_bad_addr
      $error("ecc_err_capture: ADDR_W must be 33..64");
   end
   if (SYN_W > REG_DW) begin : g_bad_syn
      $error("ecc_err_capture: SYN_W exceeds register width");
   end

   // register write decode
   logic wr_status, wr_dis, wr_en_reg, wr_sbectl;
   assign wr_status = reg_wr && (reg_addr == RA_STATUS);
   assign wr_dis    = reg_wr && (reg_addr == RA_DISABLE);
   assign wr_en_reg = reg_wr && (reg_addr == RA_IRQEN);
   assign wr_sbectl = reg_wr && (reg_addr == RA_SBECTL);

   logic [NKIND-1:0] dis_q, ien_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dis_q <= '0;
         ien_q <= '0;
      end else begin
         if (wr_dis)    dis_q <= reg_wdata[NKIND-1:0];
         if (wr_en_reg) ien_q <= reg_wdata[NKIND-1:0];
      end
   end

   // accepted events
   logic sbe_evt, mbe_evt;
   assign sbe_evt = err_valid && err_sbe && !dis_q[K_SBE];
   assign mbe_evt = err_valid && err_mbe && !dis_q[K_MBE];

   logic [CNT_W-1:0] sbe_cnt, sbe_thr;
   logic             sbe_hit;
   ecap_sbe_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .sbe_evt(sbe_evt),
      .wr_en  (wr_sbectl),
      .wr_cnt (reg_wdata[CNT_W-1:0]),
      .wr_thr (reg_wdata[THR_LSB +: CNT_W]),
      .cnt    (sbe_cnt),
      .thr    (sbe_thr),
      .hit    (sbe_hit)
   );

   logic [NKIND-1:0] set_v, clr_v, flags;
   always_comb begin
      set_v        = '0;
      set_v[K_SBE] = sbe_hit;
      set_v[K_MBE] = mbe_evt;
      clr_v        = wr_status ? reg_wdata[NKIND-1:0] : '0;
   end

   ecap_status #(.NK(NKIND), .IRQ_REG(IRQ_REG)) u_stat (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (set_v),
      .clr  (clr_v),
      .en   (ien_q),
      .flags(flags),
      .irq  (irq)
   );

   logic [DATA_W-1:0] cap_data;
   logic [SYN_W-1:0]  cap_syn;
   logic [ADDR_W-1:0] cap_addr;
   ecap_capture #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .SYN_W  (SYN_W),
      .WIDE_SW(WIDE_SW)
   ) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (sbe_evt || mbe_evt),
      .pending (|flags),
      .narrow  (cfg_narrow),
      .data    (err_data),
      .syn     (err_syndrome),
      .addr    (err_addr),
      .cap_data(cap_data),
      .cap_syn (cap_syn),
      .cap_addr(cap_addr)
   );

   // read mux
   logic [2*REG_DW-1:0] addr_pad;
   assign addr_pad = (2*REG_DW)'(cap_addr);

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_STATUS:  reg_rdata[NKIND-1:0] = flags;
         RA_DISABLE: reg_rdata[NKIND-1:0] = dis_q;
         RA_IRQEN:   reg_rdata[NKIND-1:0] = ien_q;
         RA_SBECTL: begin
            reg_rdata[CNT_W-1:0]          = sbe_cnt;
            reg_rdata[THR_LSB +: CNT_W]   = sbe_thr;
         end
         RA_CAP_DHI: reg_rdata = cap_data[DATA_W-1:REG_DW];
         RA_CAP_DLO: reg_rdata = cap_data[REG_DW-1:0];
         RA_CAP_SYN: reg_rdata[SYN_W-1:0] = cap_syn;
         RA_CAP_ALO: reg_rdata = addr_pad[REG_DW-1:0];
         RA_CAP_AHI: reg_rdata = addr_pad[2*REG_DW-1:REG_DW];
         default:    reg_rdata = '0;
      endcase
   end

   logic unused_wdata;
   assign unused_wdata = ^{reg_wdata[REG_DW-1:THR_LSB+CNT_W],
                           reg_wdata[THR_LSB-1:CNT_W]};

   AST_MASKED_MBE: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid && err_mbe && dis_q[K_MBE] && !flags[K_MBE]) |=> !flags[K_MBE]); // R7
   AST_MASKED_SBE_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid && err_sbe && dis_q[K_SBE] && !wr_sbectl) |=> $stable(sbe_cnt)); // R7
endmodule

// File: tb/ecc_err_capture_test.sv
module ecc_err_capture_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        err_valid = 1'b0, err_sbe = 1'b0, err_mbe = 1'b0;
   logic [63:0] err_data = '0;
   logic [15:0] err_syndrome = '0;
   logic [63:0] err_addr = '0;
   logic        cfg_narrow = 1'b0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   ecc_err_capture uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_valid(err_valid),
      .err_sbe(err_sbe), .err_mbe(err_mbe), .err_data(err_data),
      .err_syndrome(err_syndrome), .err_addr(err_addr),
      .cfg_narrow(cfg_narrow), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic chk_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic ev(input logic s, input logic m, input logic [63:0] d,
                     input logic [15:0] syn, input logic [63:0] a);
      @(negedge clk);
      err_valid = 1'b1; err_sbe = s; err_mbe = m;
      err_data = d; err_syndrome = syn; err_addr = a;
      @(negedge clk);
      err_valid = 1'b0; err_sbe = 1'b0; err_mbe = 1'b0;
   endtask

   task automatic t_reset();
      for (int i = 0; i <= 8; i++) chk_reg("R1 reset word", 4'(i), 32'h0);
      chk("R1 irq after reset", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_mbe();
      wr(4'd2, 32'h3);
      ev(1'b0, 1'b1, 64'hDEAD_BEEF_0123_4567, 16'h1234, 64'h0000_0012_8000_0040);
      chk_reg("R3 mbe flag", 4'd0, 32'h2);
      chk("R9 irq on mbe", {31'b0, irq}, 32'h1);
      chk_reg("R6 cap data hi", 4'd4, 32'hDEADBEEF);
      chk_reg("R6 cap data lo", 4'd5, 32'h01234567);
      chk_reg("R8 wide syndrome", 4'd6, 32'h34);
      chk_reg("R6 cap addr lo", 4'd7, 32'h80000040);
      chk_reg("R6 cap addr hi", 4'd8, 32'h00000012);
      ev(1'b0, 1'b1, 64'h1111_2222_3333_4444, 16'h00FF, 64'h5);
      chk_reg("R6 frozen data lo", 4'd5, 32'h01234567);
      chk_reg("R6 frozen addr lo", 4'd7, 32'h80000040);
      wr(4'd0, 32'h0);
      chk_reg("R2 write zero keeps", 4'd0, 32'h2);
      wr(4'd0, 32'hFFFF_FFFF);
      chk_reg("R2 all ones clears", 4'd0, 32'h0);
      chk("R9 irq drops", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_sbe_thr();
      wr(4'd3, 32'h0003_0000);
      ev(1'b1, 1'b0, 64'hA1, 16'h01, 64'h10);
      ev(1'b1, 1'b0, 64'hA2, 16'h02, 64'h20);
      chk_reg("R4 count 2 no flag", 4'd3, 32'h0003_0002);
      chk_reg("R4 no flag below thr", 4'd0, 32'h0);
      chk_reg("R6 loads while clear", 4'd5, 32'hA2);
      ev(1'b1, 1'b0, 64'hA3, 16'h03, 64'h30);
      chk_reg("R4 flag at thr", 4'd0, 32'h1);
      chk_reg("R4 count restarts", 4'd3, 32'h0003_0000);
      chk_reg("R6 third captured", 4'd5, 32'hA3);
      chk("R9 irq on sbe", {31'b0, irq}, 32'h1);
      ev(1'b0, 1'b1, 64'hA4, 16'h04, 64'h40);
      chk_reg("R5 sbe flag sticky with mbe", 4'd0, 32'h3);
      wr(4'd0, 32'h3);
      chk_reg("R2 clear both", 4'd0, 32'h0);
   endtask

   task automatic t_thr1_narrow();
      wr(4'd3, 32'h0001_0000);
      cfg_narrow = 1'b1;
      ev(1'b1, 1'b0, 64'hB0, 16'hBEEF, 64'h50);
      chk_reg("R4 thr1 flags each", 4'd0, 32'h1);
      chk_reg("R8 narrow syndrome", 4'd6, 32'h0000BEEF);
      wr(4'd0, 32'h1);
      ev(1'b1, 1'b0, 64'hB1, 16'hCAFE, 64'h60);
      chk_reg("R4 thr1 second", 4'd0, 32'h1);
      cfg_narrow = 1'b0;
      wr(4'd0, 32'h1);
   endtask

   task automatic t_disable();
      wr(4'd3, 32'h0005_0000);
      wr(4'd1, 32'h3);
      chk_reg("R7 disable readback", 4'd1, 32'h3);
      ev(1'b0, 1'b1, 64'hC0, 16'h11, 64'h70);
      ev(1'b1, 1'b0, 64'hC1, 16'h22, 64'h80);
      chk_reg("R7 no flags", 4'd0, 32'h0);
      chk_reg("R7 no count", 4'd3, 32'h0005_0000);
      chk_reg("R7 no capture", 4'd5, 32'hB1);
      wr(4'd1, 32'h0);
   endtask

   task automatic t_irq_mask();
      wr(4'd2, 32'h1);
      ev(1'b0, 1'b1, 64'hD0, 16'h33, 64'h90);
      chk_reg("R9 flag set masked", 4'd0, 32'h2);
      chk("R9 irq masked", {31'b0, irq}, 32'h0);
      wr(4'd2, 32'h2);
      chk("R9 irq enabled later", {31'b0, irq}, 32'h1);
      wr(4'd0, 32'h2);
   endtask

   task automatic t_same_cycle();
      ev(1'b0, 1'b1, 64'hE0, 16'h44, 64'hA0);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'hFFFF_FFFF;
      err_valid = 1'b1; err_mbe = 1'b1; err_data = 64'hE1; err_addr = 64'hB0;
      @(negedge clk);
      reg_wr = 1'b0; err_valid = 1'b0; err_mbe = 1'b0;
      chk_reg("R5 set beats clear", 4'd0, 32'h2);
      chk_reg("R6 gate uses old flags", 4'd5, 32'hE0);
      wr(4'd0, 32'h1);
      chk_reg("R2 clear other bit only", 4'd0, 32'h2);
      wr(4'd0, 32'h2);
      chk_reg("R2 cleared", 4'd0, 32'h0);
   endtask

   task automatic t_thr0();
      wr(4'd3, 32'h0);
      for (int i = 0; i < 3; i++) ev(1'b1, 1'b0, 64'hF0, 16'h1, 64'h0);
      chk_reg("R4 thr0 counts", 4'd3, 32'h3);
      chk_reg("R4 thr0 never flags", 4'd0, 32'h0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mbe();
      t_sbe_thr();
      t_thr1_narrow();
      t_disable();
      t_irq_mask();
      t_same_cycle();
      t_thr0();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule